// File: doc/BRIEF.md
# Push-Pull Digital PWM Controller

This block generates two alternating gate-drive pulse trains for a push-pull or half-bridge power stage. A free-running period counter serves as the oscillator, and the tail end of each period is a blanking window that forces both outputs low to provide deadtime. Each period belongs to one of the two outputs, and a phase flip-flop alternates that ownership on every period boundary. Inside its period, the selected output is high from the period start until the counter reaches the effective duty threshold. A pulse-ending latch then holds it low for the rest of that period.

The effective threshold is the smaller of the duty command register value and an internal soft-start level. That level climbs in fixed steps after reset and after lockout. A shutdown input cuts the running pulse at once. While it is held, it also bleeds the soft-start level down, so a short shutdown acts as a pulse-by-pulse limit and a long one forces a slow restart. An undervoltage-lockout input silences both outputs and keeps the soft-start level at zero. A sync input restarts the period on its rising edge, which lets several controllers be slaved together or locked to a system clock.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: Asynchronous reset drives both outputs low, clears the counter to 0, selects output A as the phase of the first period and sets the soft-start level to 0. As a result, the first pulse after reset appears on output A.
- R2: The phase toggles at every period restart, whether it comes from counter wrap or from sync. Output A can be high only in A-phase periods and output B only in B-phase periods, so the two outputs are never high together.
- R3: In its own period, an output is high for counter values 0 up to threshold-1, where the threshold is min(duty_i, soft-start level). A duty_i of 0 gives no pulse in any period.
- R4: Both outputs are low whenever counter + dead_i >= period_i. The counter runs 0..period_i-1, so each output stays below 50% of the two-period cycle.
- R5: Once a pulse has ended in a period, it cannot restart in that period, even if duty_i is raised above the current counter value.
- R6: shutdown_i passes through a 2-flop synchronizer. Both outputs are low from the second clock edge after shutdown_i rises, and a pulse cut this way stays low for the rest of its period.
- R7: While the synchronized shutdown is high, the soft-start level falls by 1 per clock, saturating at 0, and the step divider clears. A one-clock shutdown leaves later pulse widths unchanged. A shutdown held longer than 255 clocks brings pulses back only after a fresh ramp.
- R8: While uvlo_i is high, both outputs are low in the same cycle and the soft-start level is held at 0. After release, the outputs stay low for at least the next period_i cycles.
- R9: A rising edge on sync_i passes through a 2-flop synchronizer and an edge detector. On the third clock edge after sync_i rises, the counter is reset to 0 and the phase toggles.
- R10: Without shutdown or lockout, the soft-start level rises by SS_STEP (default 16) every SS_DIV (default 2) period restarts, saturating at 2^CNT_W-1. It never falls in this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| duty_i | input | CNT_W | Duty command in counter ticks |
| period_i | input | CNT_W | Period length in clocks (>= 2) |
| dead_i | input | CNT_W | Blanking length at the end of each period |
| shutdown_i | input | 1 | Asynchronous shutdown request |
| uvlo_i | input | 1 | Undervoltage lockout, synchronous to clk_i |
| sync_i | input | 1 | Asynchronous period restart request |
| out_a_o | output | 1 | Push-pull output A |
| out_b_o | output | 1 | Push-pull output B |

## Verification
Lockout acts in the same cycle, shutdown blanks the outputs two edges after its rise, and a sync rise moves the counter to 0 on the third edge. The bench therefore drives inputs at a falling edge and samples the outputs at later falling edges: it counts edges from a detected output-A rise, which marks counter value 0, and checks the exact sample at which each result is due. Pulse widths are counted over windows of twice the period, which always hold exactly one A period and one B period whatever the start phase. Each window follows a full settling span after any input change.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pp_period_cnt.sv
module pp_period_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic             sync_lvl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             blank_o,
  output logic             sync_rise_o,
  output logic             restart_o
);
  localparam logic [CNT_W:0] ONE_X = (CNT_W+1)'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             sync_d_q;
  logic             wrap;

  assign sync_rise_o = sync_lvl_i & ~sync_d_q;
  // compare in CNT_W+1 bits so period_i of 0 or 1 still wraps
  assign wrap        = ({1'b0, cnt_q} + ONE_X) >= {1'b0, period_i};
  assign restart_o   = wrap | sync_rise_o;
  assign blank_o     = ({1'b0, cnt_q} + {1'b0, dead_i}) >= {1'b0, period_i};
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sync_d_q <= 1'b0;
    end else begin
      sync_d_q <= sync_lvl_i;
      cnt_q    <= restart_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pp_softstart.sv
module pp_softstart #(
  parameter int CNT_W   = 8,
  parameter int SS_STEP = 16,
  parameter int SS_DIV  = 2,
  parameter int SS_DROP = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             discharge_i,
  input  logic             lockout_i,
  output logic [CNT_W-1:0] level_o
);
  localparam int             DIV_W  = $clog2(SS_DIV + 1);
  localparam logic [CNT_W:0] STEP_X = (CNT_W+1)'(SS_STEP);
  localparam logic [CNT_W:0] DROP_X = (CNT_W+1)'(SS_DROP);
  localparam logic [CNT_W:0] FULL_X = (CNT_W+1)'((1 << CNT_W) - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SS_DIV - 1);

  logic [CNT_W-1:0] lvl_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W:0]   up_sum;
  logic [CNT_W-1:0] up_sat;
  logic [CNT_W-1:0] dn_sat;

  assign up_sum = {1'b0, lvl_q} + STEP_X;
  assign up_sat = (up_sum > FULL_X) ? FULL_X[CNT_W-1:0] : up_sum[CNT_W-1:0];
  assign dn_sat = ({1'b0, lvl_q} > DROP_X) ? lvl_q - DROP_X[CNT_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      div_q <= '0;
    end else if (lockout_i) begin
      lvl_q <= '0;
      div_q <= '0;
    end else if (discharge_i) begin
      lvl_q <= dn_sat;
      div_q <= '0;
    end else if (restart_i) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        lvl_q <= up_sat;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl
  import pp_pwm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SS_STEP     = 16,
  parameter int SS_DIV      = 2,
  parameter int SS_DROP     = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic             shutdown_i,
  input  logic             uvlo_i,
  input  logic             sync_i,
  output logic             out_a_o,
  output logic             out_b_o
);
  localparam int N_OUT = 2;

  logic             sd_s;
  logic             sync_s;
  logic [CNT_W-1:0] cnt;
  logic             blank;
  logic             sync_rise;
  logic             restart;
  logic [CNT_W-1:0] ss_lvl;
  logic [CNT_W-1:0] thr;
  logic             below;
  logic             lat_q;
  phase_e           phase_q;
  logic             gate;
  logic [N_OUT-1:0] drv;

  pp_sync #(.STAGES(SYNC_STAGES)) u_sd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (shutdown_i),
    .q_o   (sd_s)
  );

  pp_sync #(.STAGES(SYNC_STAGES)) u_sync_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_i),
    .q_o   (sync_s)
  );

  pp_period_cnt #(.CNT_W(CNT_W)) u_osc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .period_i   (period_i),
    .dead_i     (dead_i),
    .sync_lvl_i (sync_s),
    .cnt_o      (cnt),
    .blank_o    (blank),
    .sync_rise_o(sync_rise),
    .restart_o  (restart)
  );

  pp_softstart #(
    .CNT_W  (CNT_W),
    .SS_STEP(SS_STEP),
    .SS_DIV (SS_DIV),
    .SS_DROP(SS_DROP)
  ) u_ss (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .discharge_i(sd_s),
    .lockout_i  (uvlo_i),
    .level_o    (ss_lvl)
  );

  assign thr   = (duty_i < ss_lvl) ? duty_i : ss_lvl;
  assign below = cnt < thr;

  // pulse-ending latch: set by threshold or shutdown, cleared only at a restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= 1'b0;
      phase_q <= PH_A;
    end else if (restart) begin
      lat_q   <= sd_s;
      phase_q <= (phase_q == PH_A) ? PH_B : PH_A;
    end else if (!below || sd_s) begin
      lat_q   <= 1'b1;
    end
  end

  // every off condition forces low
  assign gate = below & ~blank & ~lat_q & ~sd_s & ~uvlo_i;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    localparam phase_e OWN_PH = (i == 0) ? PH_A : PH_B;
    assign drv[i] = gate & (phase_q == OWN_PH);
  end

  assign out_a_o = drv[0];
  assign out_b_o = drv[1];
endmodule

// File: rtl/pp_pwm_chk.sv
module pp_pwm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             out_a_o,
  input logic             out_b_o,
  input logic             uvlo_i,
  input logic             sd_s,
  input logic             sync_rise,
  input logic             restart,
  input logic             blank,
  input logic             lat_q,
  input logic             phase_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ss_lvl
);
  // R2
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_a_o && out_b_o));

  // R2
  phase_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (phase_q != $past(phase_q)));

  // R4
  dead_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank |-> (!out_a_o && !out_b_o));

  // R5
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !restart) |=> lat_q);

  // R6
  sd_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_s |-> (!out_a_o && !out_b_o));

  // R7
  ss_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_s && !uvlo_i && ss_lvl != '0) |=> (ss_lvl < $past(ss_lvl)));

  // R8
  uvlo_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> (!out_a_o && !out_b_o));

  // R8
  uvlo_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (ss_lvl == '0));

  // R9
  sync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rise |=> (cnt == '0));

  // R10
  ramp_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_s && !uvlo_i) |=> (ss_lvl >= $past(ss_lvl)));
endmodule

bind pp_pwm_ctrl pp_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .out_a_o  (out_a_o),
  .out_b_o  (out_b_o),
  .uvlo_i   (uvlo_i),
  .sd_s     (sd_s),
  .sync_rise(sync_rise),
  .restart  (restart),
  .blank    (blank),
  .lat_q    (lat_q),
  .phase_q  (phase_q),
  .cnt      (cnt),
  .ss_lvl   (ss_lvl)
);

// File: tb/sim_pp_pwm_ctrl.sv
module sim_pp_pwm_ctrl;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] duty = 8'd30;
  logic [CW-1:0] period = 8'd20;
  logic [CW-1:0] dead = 8'd2;
  logic          sd = 1'b0;
  logic          uvlo = 1'b0;
  logic          sync = 1'b0;
  logic          out_a;
  logic          out_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pp_pwm_ctrl u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .duty_i    (duty),
    .period_i  (period),
    .dead_i    (dead),
    .shutdown_i(sd),
    .uvlo_i    (uvlo),
    .sync_i    (sync),
    .out_a_o   (out_a),
    .out_b_o   (out_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic win(input int n, output int ca, output int cb, output int ov);
    ca = 0; cb = 0; ov = 0;
    repeat (n) begin
      @(negedge clk);
      ca += int'(out_a);
      cb += int'(out_b);
      ov += int'(out_a & out_b);
    end
  endtask

  task automatic wait_a_rise();
    logic prev;
    prev = out_a;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (out_a && !prev) return;
      prev = out_a;
    end
  endtask

  task automatic steady(input int d, input int dt, input int exp, input string req);
    int ca, cb, ov;
    duty = CW'(d); dead = CW'(dt);
    repeat (40) @(negedge clk);
    win(40, ca, cb, ov);
    chk(ca == exp, {req, " width A"}, ca, exp);
    chk(cb == exp, {req, " width B"}, cb, exp);
    chk(ov == 0, "R2 overlap", ov, 0);
  endtask

  // R1 reset state and first pulse on A; R10 first ramp step
  task automatic t_reset();
    int ca, cb, ov, w, first;
    repeat (3) @(negedge clk);
    chk(!out_a && !out_b, "R1 outputs low in reset", int'(out_a | out_b), 0);
    rst_n = 1'b1;
    win(20, ca, cb, ov);
    chk(ca + cb == 0, "R1 low while soft-start is zero", ca + cb, 0);
    first = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (out_a) begin first = 1; break; end
      if (out_b) begin first = 2; break; end
    end
    chk(first == 1, "R1 first pulse on A (1=A 2=B)", first, 1);
    w = 0;
    while (out_a && w < 100) begin w++; @(negedge clk); end
    chk(w == 16, "R10 first soft-start step width", w, 16);
    repeat (800) @(negedge clk);
    win(40, ca, cb, ov);
    chk(ca == 18 && cb == 18, "R10 full ramp width capped by R4 blank", ca, 18);
  endtask

  // R5 raising duty after the pulse ends gives no second pulse
  task automatic t_latch();
    int ca;
    duty = 8'd5; dead = 8'd4;
    repeat (40) @(negedge clk);
    wait_a_rise();
    ca = int'(out_a);
    for (int k = 1; k < 20; k++) begin
      @(negedge clk);
      ca += int'(out_a);
      if (k == 8) duty = 8'd14;
    end
    chk(ca == 5, "R5 one pulse per period", ca, 5);
    duty = 8'd10;
  endtask

  // R6 short shutdown cuts the pulse; R7 no lasting soft-start loss
  task automatic t_short_sd();
    int ca, cb, ov;
    duty = 8'd10; dead = 8'd4;
    repeat (40) @(negedge clk);
    wait_a_rise();
    sd = 1'b1;
    ca = int'(out_a);
    @(negedge clk); sd = 1'b0; ca += int'(out_a);
    @(negedge clk);
    chk(!out_a, "R6 low two edges after shutdown", int'(out_a), 0);
    ca += int'(out_a);
    for (int k = 3; k < 20; k++) begin
      @(negedge clk);
      ca += int'(out_a);
    end
    chk(ca == 2, "R6 pulse stays cut for the period", ca, 2);
    win(40, ca, cb, ov);
    chk(ca == 10 && cb == 10, "R7 short shutdown keeps width", ca + cb, 20);
  endtask

  // R6/R7 long shutdown drains soft-start and re-ramps
  task automatic t_long_sd();
    int ca, cb, ov;
    wait_a_rise();
    sd = 1'b1;
    repeat (300) @(negedge clk);
    win(40, ca, cb, ov);
    chk(ca + cb == 0, "R6 low while shutdown held", ca + cb, 0);
    sd = 1'b0;
    win(20, ca, cb, ov);
    chk(ca + cb == 0, "R7 low after long shutdown release", ca + cb, 0);
    repeat (900) @(negedge clk);
    win(40, ca, cb, ov);
    chk(ca == 10 && cb == 10, "R7 re-ramp restores width", ca + cb, 20);
  endtask

  // R8 lockout
  task automatic t_uvlo();
    int ca, cb, ov;
    wait_a_rise();
    uvlo = 1'b1;
    @(negedge clk);
    chk(!out_a, "R8 lockout same cycle", int'(out_a), 0);
    win(100, ca, cb, ov);
    chk(ca + cb == 0, "R8 low during lockout", ca + cb, 0);
    uvlo = 1'b0;
    win(20, ca, cb, ov);
    chk(ca + cb == 0, "R8 soft-start zero after lockout", ca + cb, 0);
    repeat (900) @(negedge clk);
    win(40, ca, cb, ov);
    chk(ca == 10 && cb == 10, "R8 recovery width", ca + cb, 20);
  endtask

  // R9 sync restart
  task automatic t_sync();
    int cb;
    duty = 8'd10; dead = 8'd4;
    wait_a_rise();
    repeat (5) @(negedge clk);
    sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    @(negedge clk);
    chk(out_a, "R9 A still high before restart", int'(out_a), 1);
    @(negedge clk);
    chk(out_b && !out_a, "R9 restart hands period to B", int'(out_b), 1);
    cb = int'(out_b);
    for (int k = 1; k < 20; k++) begin
      @(negedge clk);
      cb += int'(out_b);
    end
    chk(cb == 10, "R9 B full pulse after sync", cb, 10);
  endtask

  initial begin
    t_reset();
    steady(10, 4, 10, "R3 duty 10");
    steady(30, 4, 16, "R4 dead 4 cap");
    steady(30, 8, 12, "R4 dead 8 cap");
    steady(0, 4, 0, "R3 zero duty");
    t_latch();
    t_short_sd();
    t_sync();
    t_uvlo();
    t_long_sd();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule